// File: doc/BRIEF.md
# Multi-mode register CPU core

This block is a small multi-cycle processor. It has a program counter, an instruction register, eight signed 16-bit general-purpose registers and a private 128-word synchronous memory. The core touches that memory only through its memory address register (MAR) and its memory buffer register (MBR). Each instruction is fetched as one word and decoded into an opcode, a destination register, an addressing mode and a 7-bit final field. The core then gathers the operand and either writes a result back to the destination register or writes the destination register to memory.

Before a run, a testbench or a boot agent fills the memory through a preload port while the core is idle. A pulse on `go` then starts execution at address 0. The core announces every register writeback and every memory store on registered event outputs. It stops for good, raising `halted`, when it meets an instruction it cannot execute.

Top module: `regcpu_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `halted`, `wb_valid` and `st_valid` are 0. Reset clears all eight registers and the program counter to 0.
- R2: After reset the core stays idle until `go` is sampled high. While idle, a cycle with `ld_en` high writes `ld_data` into memory cell `ld_addr`. The first instruction is fetched from address 0.
- R3: An instruction word holds the opcode in bits 15:12, the destination register in bits 11:9, the mode in bits 8:7 and the final field in bits 6:0. The opcodes are LOAD=0, STORE=1, ADD=2, SUB=3, MUL=4 and DIV=5.
- R4: The operand depends on the mode. Mode 0 reads memory at the field. Mode 1 reads register field[2:0]. Mode 2 reads memory at bits 6:0 of register field[2:0]. Mode 3 takes the field sign-extended as a constant from -64 to 63. LOAD copies the operand into the destination register.
- R5: ADD, SUB and MUL write dst+operand, dst-operand and dst*operand to the destination register, keeping the low 16 bits of the two's-complement result.
- R6: DIV writes operand/dst to the destination register, truncated toward zero. The case -32768 / -1 gives -32768.
- R7: STORE (mode 0) writes the destination register into memory at the field. For one cycle it raises `st_valid`, with `st_addr` and `st_data` giving the cell and the value. Later reads of that cell return the stored value.
- R8: The core halts on any of three conditions: an opcode above 5, a STORE whose mode is not 0, or a DIV whose destination register holds 0. When it halts, `halted` goes to 1 and stays there until reset. The faulting instruction changes no register and no memory cell, and no event follows.
- R9: Every register writeback raises `wb_valid` for exactly one cycle, with `wb_reg` and `wb_data` giving the register and its new value. `wb_valid` and `st_valid` are never high together.
- R10: Memory is accessed at most once per cycle, only by a preload while idle or through the MAR/MBR pair. The program counter changes only when the instruction register is loaded. Counting from the cycle where an instruction's fetch begins:
  - Register-mode, constant-mode and STORE instructions complete in 6 cycles.
  - Direct and indirect instructions complete in 8 cycles.
  - A decode-time halt appears after 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start execution from address 0 (sampled while idle) |
| ld_en | input | 1 | Preload write strobe, honoured while idle |
| ld_addr | input | 7 | Preload cell address |
| ld_data | input | 16 | Preload word |
| halted | output | 1 | Core has stopped on an unexecutable instruction |
| wb_valid | output | 1 | One-cycle register writeback event |
| wb_reg | output | 3 | Register written |
| wb_data | output | 16 | Value written |
| st_valid | output | 1 | One-cycle memory store event |
| st_addr | output | 7 | Cell stored to |
| st_data | output | 16 | Value stored |

## Verification
The bound checker watches several properties on every cycle:
- `halted` stays high once set, and no event follows a halt.
- A divide with a zero destination register goes straight to halt.
- Writeback and store events never coincide, and every store event follows a memory write.
- The memory is written only while idle or in the store step.
- The program counter moves only when an instruction is captured.
- The core stays idle until started.

The arithmetic results, the four operand sources and the exact cycle of each event come only from the bench's scenarios. These include wrapping multiply, signed division with its overflow case, reading back a stored cell, and each of the three halt causes. The bench checks them against an instruction-level model that predicts each event's cycle.

// File: rtl/regcpu_pkg.sv
package regcpu_pkg;
  localparam int OPC_W  = 4;
  localparam int MODE_W = 2;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd0;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd1;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd2;
  localparam logic [OPC_W-1:0] OP_SUB   = 4'd3;
  localparam logic [OPC_W-1:0] OP_MUL   = 4'd4;
  localparam logic [OPC_W-1:0] OP_DIV   = 4'd5;

  localparam logic [MODE_W-1:0] MD_DIR = 2'd0;
  localparam logic [MODE_W-1:0] MD_REG = 2'd1;
  localparam logic [MODE_W-1:0] MD_IND = 2'd2;
  localparam logic [MODE_W-1:0] MD_CON = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_FA, S_FR, S_FM, S_FI, S_DC, S_OR, S_OM, S_EX, S_SW, S_HLT
  } state_t;
endpackage

// File: rtl/regcpu_mem.sv
module regcpu_mem #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // single port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= cells[addr];
  end
endmodule

// File: rtl/regcpu_regfile.sv
module regcpu_regfile #(
  parameter int W     = 16,
  parameter int N     = 8,
  parameter int SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [SEL_W-1:0] raddr_a,
  output logic [W-1:0]     rdata_a,
  input  logic [SEL_W-1:0] raddr_b,
  output logic [W-1:0]     rdata_b
);
  logic [W-1:0] bank [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (we && waddr == SEL_W'(i)) q <= wdata;
    end
    assign bank[i] = q;
  end

  assign rdata_a = bank[raddr_a];
  assign rdata_b = bank[raddr_b];
endmodule

// File: rtl/regcpu_alu.sv
module regcpu_alu
  import regcpu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPC_W-1:0] op,
  input  logic [W-1:0]     dst,
  input  logic [W-1:0]     opnd,
  output logic [W-1:0]     res,
  output logic             div_zero
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] s_dst, s_opnd;
  assign s_dst  = dst;
  assign s_opnd = opnd;

  always_comb begin
    div_zero = (op == OP_DIV) && (dst == '0);
    case (op)
      OP_ADD:  res = dst + opnd;
      OP_SUB:  res = dst - opnd;
      OP_MUL:  res = dst * opnd;
      OP_DIV: begin
        if (dst == '0)                          res = '0;
        else if (opnd == MINV && dst == '1)     res = MINV;
        else                                    res = s_opnd / s_dst;
      end
      default: res = opnd;
    endcase
  end
endmodule

// File: rtl/regcpu_top.sv
module regcpu_top
  import regcpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7,
  parameter int NREG   = 8,
  parameter int RSEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              halted,
  output logic              wb_valid,
  output logic [RSEL_W-1:0] wb_reg,
  output logic [DATA_W-1:0] wb_data,
  output logic              st_valid,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data
);
  localparam int M_LSB = ADDR_W;
  localparam int D_LSB = M_LSB + MODE_W;
  localparam int O_LSB = D_LSB + RSEL_W;

  state_t            state;
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, ir;

  logic [OPC_W-1:0]  f_op;
  logic [RSEL_W-1:0] f_dst;
  logic [MODE_W-1:0] f_mode;
  logic [ADDR_W-1:0] f_field;
  assign f_op    = ir[O_LSB +: OPC_W];
  assign f_dst   = ir[D_LSB +: RSEL_W];
  assign f_mode  = ir[M_LSB +: MODE_W];
  assign f_field = ir[ADDR_W-1:0];

  logic [DATA_W-1:0] imm, rd_a, rd_b, opnd, alu_res, mem_rdata, mem_wdata;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we, div_zero, legal, rf_we;

  assign imm   = {{(DATA_W-ADDR_W){f_field[ADDR_W-1]}}, f_field};
  assign legal = (f_op <= OP_DIV) && !(f_op == OP_STORE && f_mode != MD_DIR);

  always_comb begin
    case (f_mode)
      MD_REG:  opnd = rd_b;
      MD_CON:  opnd = imm;
      default: opnd = mbr;
    endcase
  end

  // preload owns the port while idle, MAR/MBR own it otherwise
  assign mem_we    = (state == S_IDLE) ? ld_en   : (state == S_SW);
  assign mem_addr  = (state == S_IDLE) ? ld_addr : mar;
  assign mem_wdata = (state == S_IDLE) ? ld_data : mbr;
  assign rf_we     = (state == S_EX) && !div_zero;

  regcpu_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  regcpu_regfile #(.W(DATA_W), .N(NREG), .SEL_W(RSEL_W)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(f_dst), .wdata(alu_res),
    .raddr_a(f_dst), .rdata_a(rd_a),
    .raddr_b(f_field[RSEL_W-1:0]), .rdata_b(rd_b)
  );

  regcpu_alu #(.W(DATA_W)) u_alu (
    .op(f_op), .dst(rd_a), .opnd(opnd), .res(alu_res), .div_zero(div_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      pc       <= '0;
      mar      <= '0;
      mbr      <= '0;
      ir       <= '0;
      halted   <= 1'b0;
      wb_valid <= 1'b0;
      wb_reg   <= '0;
      wb_data  <= '0;
      st_valid <= 1'b0;
      st_addr  <= '0;
      st_data  <= '0;
    end else begin
      wb_valid <= 1'b0;
      st_valid <= 1'b0;
      case (state)
        S_IDLE: if (go) state <= S_FA;
        S_FA: begin
          mar   <= pc;
          state <= S_FR;
        end
        S_FR: state <= S_FM;
        S_FM: begin
          mbr   <= mem_rdata;
          state <= S_FI;
        end
        S_FI: begin
          ir    <= mbr;
          pc    <= pc + ADDR_W'(1);
          state <= S_DC;
        end
        S_DC: begin
          if (!legal) begin
            halted <= 1'b1;
            state  <= S_HLT;
          end else if (f_op == OP_STORE) begin
            mar   <= f_field;
            mbr   <= rd_a;
            state <= S_SW;
          end else if (f_mode == MD_DIR) begin
            mar   <= f_field;
            state <= S_OR;
          end else if (f_mode == MD_IND) begin
            mar   <= rd_b[ADDR_W-1:0];
            state <= S_OR;
          end else begin
            state <= S_EX;
          end
        end
        S_OR: state <= S_OM;
        S_OM: begin
          mbr   <= mem_rdata;
          state <= S_EX;
        end
        S_EX: begin
          if (div_zero) begin
            halted <= 1'b1;
            state  <= S_HLT;
          end else begin
            wb_valid <= 1'b1;
            wb_reg   <= f_dst;
            wb_data  <= alu_res;
            state    <= S_FA;
          end
        end
        S_SW: begin
          st_valid <= 1'b1;
          st_addr  <= mar;
          st_data  <= mbr;
          state    <= S_FA;
        end
        default: state <= S_HLT;
      endcase
    end
  end
endmodule

// File: rtl/regcpu_checker.sv
module regcpu_checker
  import regcpu_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              go,
  input state_t            state,
  input logic [ADDR_W-1:0] pc,
  input logic              mem_we,
  input logic              div_zero,
  input logic              halted,
  input logic              wb_valid,
  input logic              st_valid
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!halted && !wb_valid && !st_valid && pc == '0));

  assert_wait_for_go_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !go) |=> state == S_IDLE);

  assert_div_zero_halts_R6: assert property (@(posedge clk) disable iff (rst)
    (state == S_EX && div_zero) |=> (halted && !wb_valid));

  assert_store_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> $past(mem_we));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_silent_halt_R8: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!wb_valid && !st_valid));

  assert_single_event_R9: assert property (@(posedge clk) disable iff (rst)
    !(wb_valid && st_valid));

  assert_mem_path_R10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == S_IDLE || state == S_SW));

  assert_pc_moves_on_fetch_R10: assert property (@(posedge clk) disable iff (rst)
    (state != S_FI) |=> $stable(pc));
endmodule

bind regcpu_top regcpu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .go(go), .state(state), .pc(pc), .mem_we(mem_we),
  .div_zero(div_zero), .halted(halted), .wb_valid(wb_valid), .st_valid(st_valid)
);

// File: tb/regcpu_top_bench.sv
`timescale 1ns/1ps
module regcpu_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic        ld_en = 1'b0;
  logic [6:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        halted, wb_valid, st_valid;
  logic [2:0]  wb_reg;
  logic [15:0] wb_data, st_data;
  logic [6:0]  st_addr;

  always #2 clk = ~clk;  // 250 MHz

  regcpu_top u_regcpu_top (
    .clk(clk), .rst(rst), .go(go), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .halted(halted), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [15:0]        mm [128];
  logic signed [15:0] rf [8];
  int    q_edge[$], q_kind[$], q_idx[$], q_data[$];
  string q_tag[$];
  int    halt_edge;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // R3 word layout: op[15:12] dst[11:9] mode[8:7] field[6:0]
  function automatic logic [15:0] enc(input int op, input int d, input int m, input int f);
    return 16'(((op & 15) << 12) | ((d & 7) << 9) | ((m & 3) << 7) | (f & 127));
  endfunction

  task automatic ld(input int a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 7'(a); ld_data = d; mm[a] = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // instruction-level model; go sampled on edge 0
  task automatic model();
    int s = 0;
    int pcm = 0;
    for (int i = 0; i < 8; i++) rf[i] = '0;
    halt_edge = -1;
    for (int hop = 0; hop < 200; hop++) begin
      logic [15:0] w;
      logic [6:0]  fw;
      int op, d, m, lat;
      logic signed [15:0] a, b, r;
      string tg;
      w = mm[pcm]; pcm = (pcm + 1) % 128;
      op = int'(w[15:12]); d = int'(w[11:9]); m = int'(w[8:7]); fw = w[6:0];
      if (op > 5 || (op == 1 && m != 0)) begin halt_edge = s + 5; break; end
      if (op == 1) begin
        mm[fw] = rf[d];
        q_edge.push_back(s + 6); q_kind.push_back(1); q_idx.push_back(int'(fw));
        q_data.push_back(int'(rf[d])); q_tag.push_back("R7");
        s += 6;
        continue;
      end
      case (m)
        0: b = mm[fw];
        1: b = rf[fw[2:0]];
        2: b = mm[rf[fw[2:0]][6:0]];
        default: b = {{9{fw[6]}}, fw};
      endcase
      lat = (m == 0 || m == 2) ? 8 : 6;
      a = rf[d];
      if (op == 5 && a == 0) begin halt_edge = s + lat; break; end
      case (op)
        0: begin r = b; tg = "R4"; end
        2: begin r = a + b; tg = "R5"; end
        3: begin r = a - b; tg = "R5"; end
        4: begin r = a * b; tg = "R5"; end
        default: begin
          if (b == -16'sd32768 && a == -16'sd1) r = b;
          else r = b / a;
          tg = "R6";
        end
      endcase
      rf[d] = r;
      q_edge.push_back(s + lat); q_kind.push_back(0); q_idx.push_back(d);
      q_data.push_back(int'(r)); q_tag.push_back(tg);
      s += lat;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(!halted && !wb_valid && !st_valid, "R1", "outputs in reset",
        int'({halted, wb_valid, st_valid}), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!halted && !wb_valid && !st_valid, "R1", "outputs after reset",
        int'({halted, wb_valid, st_valid}), 0);
  endtask

  task automatic run_prog(input string name);
    model();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    for (int n = 1; n <= halt_edge + 3; n++) begin
      @(negedge clk);
      if (q_edge.size() > 0 && q_edge[0] == n) begin
        int k = q_kind.pop_front();
        int ix = q_idx.pop_front();
        int dv = q_data.pop_front();
        string tg = q_tag.pop_front();
        void'(q_edge.pop_front());
        if (k == 0) begin
          chk(wb_valid && !st_valid && int'(wb_reg) == ix, {"R9 ", name}, "wb_reg",
              int'(wb_reg), ix);
          chk(wb_data == 16'(dv), {"R3 ", tg, " ", name}, "wb_data",
              int'($signed(wb_data)), dv);
        end else begin
          chk(st_valid && !wb_valid && int'(st_addr) == ix, {"R7 ", name}, "st_addr",
              int'(st_addr), ix);
          chk(st_data == 16'(dv), {"R7 ", name}, "st_data", int'($signed(st_data)), dv);
        end
      end else begin
        chk(!wb_valid && !st_valid, {"R10 ", name}, "unexpected event",
            int'({wb_valid, st_valid}), 0);
      end
      chk(halted == (n >= halt_edge), {"R8 ", name}, "halted", int'(halted),
          int'(n >= halt_edge));
    end
    chk(q_edge.size() == 0, {"R9 ", name}, "missing events", q_edge.size(), 0);
    q_edge.delete(); q_kind.delete(); q_idx.delete(); q_data.delete(); q_tag.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!halted && !wb_valid && !st_valid, "R1", "outputs in reset",
        int'({halted, wb_valid, st_valid}), 0);
    @(negedge clk); rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!halted && !wb_valid && !st_valid, "R2", "idle before go",
          int'({halted, wb_valid, st_valid}), 0);
    end

    // program 1: all four modes, add/sub/mul, store and read back, R1 zeroed regs
    ld(40, 16'd1000); ld(41, -16'sd300); ld(42, 16'd3);
    ld(0, enc(0, 1, 0, 40));
    ld(1, enc(0, 2, 3, -5));
    ld(2, enc(2, 1, 1, 2));
    ld(3, enc(0, 3, 3, 41));
    ld(4, enc(0, 4, 2, 3));
    ld(5, enc(3, 1, 1, 4));
    ld(6, enc(4, 1, 0, 42));
    ld(7, enc(1, 1, 0, 45));
    ld(8, enc(0, 5, 0, 45));
    ld(9, enc(2, 6, 1, 6));
    ld(10, 16'hF000);
    run_prog("p1 modes");

    // program 2: division corner cases and multiply wrap
    do_reset();
    ld(40, 16'd100); ld(41, -16'sd7); ld(43, 16'h8000);
    ld(0, enc(0, 1, 3, 7));
    ld(1, enc(5, 1, 0, 40));
    ld(2, enc(0, 2, 3, 3));
    ld(3, enc(5, 2, 0, 41));
    ld(4, enc(0, 3, 3, -1));
    ld(5, enc(0, 4, 0, 43));
    ld(6, enc(5, 3, 1, 4));
    ld(7, enc(4, 4, 3, 2));
    ld(8, enc(0, 5, 3, -64));
    ld(9, enc(3, 5, 3, 63));
    ld(10, enc(9, 0, 0, 0));
    run_prog("p2 divide");

    // program 3: store in register mode halts (R8)
    do_reset();
    ld(0, enc(0, 1, 3, 5));
    ld(1, enc(1, 1, 1, 45));
    ld(2, enc(0, 2, 3, 9));
    run_prog("p3 bad store");

    // program 4: divide by zero destination halts (R6, R8)
    do_reset();
    ld(0, enc(0, 2, 3, 9));
    ld(1, enc(5, 0, 1, 2));
    ld(2, enc(0, 3, 3, 1));
    run_prog("p4 div zero");

    // program 5: cell 45 unchanged by the faulting store
    do_reset();
    ld(0, enc(0, 2, 0, 45));
    ld(1, 16'hF000);
    run_prog("p5 readback");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule